// File: doc/BRIEF.md
# Multi-Master Bus Arbitration Transmitter

This block is the transmit side of a two-wire serial bus master that shares the bus with other masters. It takes bytes through a valid/ready handshake. The first byte of a frame is the address byte: seven address bits followed by the read/write flag. Later bytes are data. Each byte is driven onto the open-drain data line most significant bit first. An SCL unit outside the block supplies one-cycle strobes for each rising and falling edge of the clock line.

The bus is a wired-AND, so on every rising clock edge the block reads the data line back and compares it with what it meant to send. If it released the line for a one and reads a zero, another master has won. The block then releases the line for the rest of the packet and raises a sticky loss flag. It keeps counting clock edges until the packet, including its acknowledge slot, is over.

When the loss happens inside an address byte, the block acts as a slave for the rest of that byte. It collects the winner's bits, which include the bits it had already read back before losing. If the winner's seven address bits equal the block's own slave address, the block gives a one-cycle pulse and reports the winner's read/write bit. The winner's frame then continues, and so arbitration can also be lost in a data byte when two masters sent the same address.

Top module: `mmArbTx`

## Requirements
- R1: A byte is accepted when txValid and txReady are both high on a clock edge. From the next cycle the block drives the byte's bit 7, and each SCL fall strobe moves it to the next lower bit. sdaOe=1 means the line is pulled low for a 0 bit; sdaOe=0 releases it for a 1 bit. sdaOe changes only in the cycle after an accepted byte or after an SCL fall.
- R2: The bus is sampled on each SCL rise strobe. Arbitration is lost only when the block was releasing the line (sdaOe=0, intending a 1) and sdaIn reads 0. Reading 0 while driving 0 is never a loss. lost goes high in the cycle after that rise strobe.
- R3: Once arbitration is lost, sdaOe stays 0 for the rest of the packet. lost stays high across packets until lostClr is pulsed, and it clears on the cycle after that pulse.
- R4: The ninth clock of each byte is the acknowledge slot. sdaOe is 0 during it, and a low bus level read in that slot never raises lost.
- R5: After a loss, the block still follows SCL strobes until the end of the acknowledge slot. The packet ends with the SCL fall that closes the acknowledge slot.
- R6: If the loss happens during an address byte, the block checks the eight bits read from the bus, including those read before the loss. On the rise strobe of the eighth bit it pulses addressed for exactly one cycle when bits 7..1 equal ownAddr, and addrRw gives bit 0 of that byte.
- R7: A loss during a data byte (txFirst was 0 when the byte was accepted) never pulses addressed.
- R8: Arbitration checking continues through the data bytes, so a mismatch in any data bit raises lost just as one in the address byte does.
- R9: txReady is high only while no packet is in flight and lost is low. A byte offered at any other time is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclRise | input | 1 | One-cycle strobe at each SCL rising edge |
| sclFall | input | 1 | One-cycle strobe at each SCL falling edge |
| txByte | input | 8 | Byte to send |
| txFirst | input | 1 | Marks txByte as the address byte of a frame |
| txValid | input | 1 | txByte is offered |
| txReady | output | 1 | Block can accept a byte |
| ownAddr | input | 7 | This device's slave address |
| sdaIn | input | 1 | Sampled level of the data line |
| sdaOe | output | 1 | 1 pulls the data line low |
| lostClr | input | 1 | Clears the sticky loss flag |
| lost | output | 1 | Sticky arbitration-lost flag |
| addressed | output | 1 | One-cycle pulse: the winner addressed this device |
| addrRw | output | 1 | Read/write bit of the matching address byte |

## Verification
The checker watches several rules on every cycle. No drive happens while lost is high. A new loss needs a released line that read back low on a rise strobe. The data line stays released after the block enters the acknowledge slot. sdaOe changes only after a fall strobe or an accepted byte. The addressed pulse lasts one cycle and comes only with a loss. txReady never coincides with a drive or a loss. The rest needs a bus model with a competing master, which only the bench's scenarios provide. That covers the correct MSB-first bit values, the loss landing on the exact bit where the two masters diverge, and the address compare using bits read before the loss. It also covers a data-byte loss that gives no address pulse and a low acknowledge slot that gives no loss.

// File: rtl/arbTxPkg.sv
package arbTxPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BITS, ST_ACK} txState_e;

  typedef struct packed {
    logic load;      // byte accepted from the handshake
    logic sample;    // SCL rise during a data bit
    logic shift;     // SCL fall moving to next bit
    logic ackEnter;  // SCL fall after last bit, entering acknowledge slot
  } ctrlStrobes_t;
endpackage

// File: rtl/arbTxCtrl.sv
module arbTxCtrl
  import arbTxPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclRise,
  input  logic         sclFall,
  input  logic         txValid,
  input  logic         lastBit,
  input  logic         lostFlag,
  output logic         txReady,
  output ctrlStrobes_t strobe
);
  txState_e state, stateNext;

  always_comb begin
    strobe          = '0;
    stateNext       = state;
    strobe.load     = (state == ST_IDLE) && txValid && !lostFlag;
    strobe.sample   = (state == ST_BITS) && sclRise;
    strobe.shift    = (state == ST_BITS) && sclFall && !lastBit;
    strobe.ackEnter = (state == ST_BITS) && sclFall && lastBit;
    unique case (state)
      ST_IDLE: if (strobe.load) stateNext = ST_BITS;
      ST_BITS: if (strobe.ackEnter) stateNext = ST_ACK;
      ST_ACK:  if (sclFall) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign txReady = (state == ST_IDLE) && !lostFlag;
endmodule

// File: rtl/arbTxDatapath.sv
module arbTxDatapath
  import arbTxPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobe,
  input  logic [BYTE_W-1:0] txByte,
  input  logic              txFirst,
  input  logic [BYTE_W-2:0] ownAddr,
  input  logic              sdaIn,
  input  logic              lostClr,
  output logic              sdaOe,
  output logic              lostFlag,
  output logic              lastBit,
  output logic              addressed,
  output logic              addrRw
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] txSh, rxSh, rxNext;
  logic [CNT_W-1:0]  bitCnt;
  logic isAddr, lostPkt, driveLow;
  logic lossNow, lostAfter, addrMatch;

  assign lastBit   = (bitCnt == LAST_IDX);
  assign rxNext    = {rxSh[BYTE_W-2:0], sdaIn};
  // loss: we released the line (wanted a 1) but the bus reads 0
  assign lossNow   = strobe.sample && !lostPkt && !driveLow && !sdaIn;
  assign lostAfter = lostPkt || lossNow;
  assign addrMatch = (rxNext[BYTE_W-1:1] == ownAddr);
  assign sdaOe     = driveLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh      <= '0;
      rxSh      <= '0;
      bitCnt    <= '0;
      isAddr    <= 1'b0;
      lostPkt   <= 1'b0;
      driveLow  <= 1'b0;
      lostFlag  <= 1'b0;
      addressed <= 1'b0;
      addrRw    <= 1'b0;
    end else begin
      addressed <= 1'b0;
      if (strobe.load) begin
        txSh     <= txByte;
        bitCnt   <= '0;
        isAddr   <= txFirst;
        lostPkt  <= 1'b0;
        driveLow <= ~txByte[BYTE_W-1];
      end
      if (strobe.sample) begin
        rxSh <= rxNext;
        if (lossNow) begin
          lostPkt  <= 1'b1;
          driveLow <= 1'b0;
        end
        if (lastBit && isAddr && lostAfter && addrMatch) begin
          addressed <= 1'b1;
          addrRw    <= rxNext[0];
        end
      end
      if (strobe.shift) begin
        txSh     <= txSh << 1;
        bitCnt   <= bitCnt + 1'b1;
        driveLow <= !lostPkt && !txSh[BYTE_W-2];
      end
      if (strobe.ackEnter) driveLow <= 1'b0;
      if (lossNow)      lostFlag <= 1'b1;
      else if (lostClr) lostFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/mmArbTx.sv
module mmArbTx
  import arbTxPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic [BYTE_W-1:0] txByte,
  input  logic              txFirst,
  input  logic              txValid,
  output logic              txReady,
  input  logic [BYTE_W-2:0] ownAddr,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              lostClr,
  output logic              lost,
  output logic              addressed,
  output logic              addrRw
);
  ctrlStrobes_t strobe;
  logic lastBit;
  logic ackEnterW;

  assign ackEnterW = strobe.ackEnter;

  arbTxCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .txValid(txValid), .lastBit(lastBit), .lostFlag(lost),
    .txReady(txReady), .strobe(strobe)
  );

  arbTxDatapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txByte(txByte),
    .txFirst(txFirst), .ownAddr(ownAddr), .sdaIn(sdaIn), .lostClr(lostClr),
    .sdaOe(sdaOe), .lostFlag(lost), .lastBit(lastBit),
    .addressed(addressed), .addrRw(addrRw)
  );
endmodule

// File: rtl/mmArbTxChk.sv
module mmArbTxChk (
  input logic clk,
  input logic rstN,
  input logic sclRise,
  input logic sclFall,
  input logic txValid,
  input logic txReady,
  input logic sdaIn,
  input logic sdaOe,
  input logic lost,
  input logic addressed,
  input logic ackEnter
);
  p_no_drive_lost_r3: assert property (@(posedge clk) disable iff (!rstN)
    lost |-> !sdaOe);

  p_loss_released_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lost) |-> $past(sclRise && !sdaOe && !sdaIn));

  p_ack_released_r4: assert property (@(posedge clk) disable iff (!rstN)
    ackEnter |=> !sdaOe);

  p_drive_timing_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> $past(sclFall || (txValid && txReady)));

  p_addr_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    addressed |=> !addressed);

  p_addr_needs_loss_r6: assert property (@(posedge clk) disable iff (!rstN)
    addressed |-> lost);

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (!sdaOe && !lost));
endmodule

bind mmArbTx mmArbTxChk u_chk (
  .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
  .txValid(txValid), .txReady(txReady), .sdaIn(sdaIn), .sdaOe(sdaOe),
  .lost(lost), .addressed(addressed), .ackEnter(ackEnterW)
);

// File: tb/tb_mmArbTx.sv
module tb_mmArbTx;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclRise = 1'b0, sclFall = 1'b0;
  logic [7:0] txByte = '0;
  logic txFirst = 1'b0, txValid = 1'b0, lostClr = 1'b0;
  logic othLow = 1'b0;
  logic txReady, sdaIn, sdaOe, lost, addressed, addrRw;

  int nChk = 0, nFail = 0;
  bit lostM = 0, othLostM = 0, finished = 0;
  logic [7:0] rxM = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdaIn = !(sdaOe || othLow);

  mmArbTx dut (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .txByte(txByte), .txFirst(txFirst), .txValid(txValid), .txReady(txReady),
    .ownAddr(OWN), .sdaIn(sdaIn), .sdaOe(sdaOe), .lostClr(lostClr),
    .lost(lost), .addressed(addressed), .addrRw(addrRw)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expDrive(input bit lostNow, input bit bitVal);
    return !lostNow && !bitVal;
  endfunction

  task automatic pulseRise();
    sclRise = 1'b1; @(negedge clk); sclRise = 1'b0;
  endtask

  task automatic pulseFall();
    sclFall = 1'b1; @(negedge clk); sclFall = 1'b0;
  endtask

  task automatic doByte(input logic [7:0] mine, input bit first,
                        input logic [7:0] oth, input bit othOn, input bit ackLow);
    bit busBit, expA;
    chk(txReady == !lostM, "R9 ready before byte", txReady, !lostM);
    txByte = mine; txFirst = first; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      chk(sdaOe == expDrive(lostM, mine[i]), "R1/R3 drive value", sdaOe, expDrive(lostM, mine[i]));
      if (i == 7) chk(txReady == 1'b0, "R9 busy in packet", txReady, 0);
      othLow = othOn && !othLostM && !oth[i];
      busBit = !(expDrive(lostM, mine[i]) || othLow);
      pulseRise();
      if (!lostM && mine[i] && !busBit) lostM = 1;
      if (othOn && !othLostM && oth[i] && !busBit) othLostM = 1;
      rxM = {rxM[6:0], busBit};
      chk(lost == lostM, first ? "R2 loss in address" : "R8 loss in data", lost, lostM);
      if (i == 0) begin
        expA = first && lostM && (rxM[7:1] == OWN);
        chk(addressed == expA, first ? "R6 address match" : "R7 no match on data", addressed, expA);
        if (expA) chk(addrRw == rxM[0], "R6 rw bit", addrRw, rxM[0]);
      end
      othLow = 1'b0;
      pulseFall();
      if (i == 0) chk(addressed == 1'b0, "R6 single-cycle pulse", addressed, 0);
    end
    chk(sdaOe == 1'b0, "R4 released in ack", sdaOe, 0);
    othLow = ackLow;
    pulseRise();
    chk(lost == lostM, "R4 no arbitration in ack", lost, lostM);
    othLow = 1'b0;
    chk(txReady == 1'b0, "R5 still in packet", txReady, 0);
    pulseFall();
    chk(txReady == !lostM, "R5 packet ends after ack", txReady, !lostM);
  endtask

  task automatic frame(input logic [7:0] aMine, input logic [7:0] aOth,
                       input logic [23:0] dMine, input logic [23:0] dOth,
                       input int nData, input bit othOn, input bit ackLow);
    othLostM = 0;
    doByte(aMine, 1'b1, aOth, othOn, ackLow);
    for (int k = 0; k < nData; k++) begin
      if (lostM) break;
      doByte(dMine[8*k +: 8], 1'b0, dOth[8*k +: 8], othOn, ackLow);
    end
    if (lostM) begin
      // offer a byte while lost: it must not be taken
      txByte = 8'h00; txFirst = 1'b1; txValid = 1'b1;
      @(negedge clk);
      txValid = 1'b0;
      chk(sdaOe == 1'b0, "R9 no load while lost", sdaOe, 0);
      chk(lost == 1'b1, "R3 sticky", lost, 1);
      lostClr = 1'b1; @(negedge clk); lostClr = 1'b0;
      lostM = 0;
      chk(lost == 1'b0, "R3 clear", lost, 0);
      chk(txReady == 1'b1, "R9 ready after clear", txReady, 1);
    end
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(sdaOe == 1'b0, "R1 reset drive", sdaOe, 0);
    chk(lost == 1'b0, "R3 reset lost", lost, 0);
    chk(txReady == 1'b1, "R9 reset ready", txReady, 1);
    chk(addressed == 1'b0, "R6 reset addressed", addressed, 0);

    // alone on the bus, low acknowledge
    frame(8'h60, 8'h00, 24'hA5_3C_C3, 24'h0, 3, 1'b0, 1'b1);
    // R8: same address, divergence in second data byte
    frame(8'h60, 8'h60, 24'h00_3F_11, 24'h00_37_11, 2, 1'b1, 1'b0);
    // R6: lose in address, winner targets own address (write)
    frame(8'hC0, 8'hB4, 24'h0, 24'h0, 1, 1'b1, 1'b1);
    // R6: lose in address, winner targets other address
    frame(8'hC0, 8'hA2, 24'h0, 24'h0, 1, 1'b1, 1'b0);
    // R6: lose on the rw bit itself
    frame(8'hB5, 8'hB4, 24'h0, 24'h0, 1, 1'b1, 1'b0);
    // R2: we drive 0 where other drives 1, we win
    frame(8'h20, 8'hA0, 24'h00_00_0F, 24'h00_00_FF, 1, 1'b1, 1'b1);
    // R7: other sends own address too, loss only in data
    frame(8'hB4, 8'hB4, 24'h00_00_80, 24'h00_00_00, 1, 1'b1, 1'b0);

    for (int f = 0; f < 40; f++) begin
      logic [7:0] aM, aO;
      logic [23:0] dM, dO;
      aM = 8'($urandom);
      aO = ($urandom % 2 == 0) ? {OWN, 1'($urandom)} : 8'($urandom);
      if ($urandom % 4 == 0) aO = aM;
      dM = 24'($urandom);
      dO = ($urandom % 2 == 0) ? dM ^ 24'(1 << ($urandom % 24)) : 24'($urandom);
      frame(aM, aO, dM, dO, 1 + int'($urandom % 3), ($urandom % 4) != 0, 1'($urandom));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end
endmodule